// File: doc/BRIEF.md
# DMA Global Control and Status Register File

This block holds the chip-wide control and status words of a multi-channel DMA engine. A host reaches them through a plain register port: one 8-bit offset, a write strobe with write data, and a read strobe. The registers sit in a 256-byte window. Five of them are plain storage words that hold global control, channel priority control, a skip quadword count, a ring buffer size and a ring buffer offset. The sixth is the status word, and its two halves behave differently. The low half holds pending interrupt flags. A write clears them one bit at a time wherever the written bit is 1. The high half holds the interrupt mask, and a write overwrites it outright.

Channel completion logic is outside this block, so a set input stands in for it. Any bit raised on `set_flags` is ORed into the pending flags on the next edge. A set and a clear of the same bit in the same cycle leave the bit set. Reads are registered and answered one cycle later with a read-valid pulse. An optional trace output reports every access one cycle after it happens, and flags whether the offset was mapped. The block carries no data path for transfers.

Top module: `dma_glob_regs`

## Requirements
- R1: After reset all six registers read 0x00000000, `rd_valid` is 0 and the trace outputs are 0. A status of zero means nothing is pending.
- R2: The words at offsets 0x00 (control), 0x20 (priority), 0x30 (skip count), 0x40 (ring size) and 0x50 (ring offset) read back the last full 32-bit value written to them.
- R3: A write to offset 0x10 clears each bit of status [15:0] whose written bit is 1, and leaves the bits whose written bit is 0 unchanged.
- R4: A write to offset 0x10 loads status [31:16] directly with written bits [31:16], including zero bits.
- R5: Each 1 on `set_flags[15:0]` sets the matching status bit on the next edge. When a status write clears a bit in the same cycle that `set_flags` sets it, the bit ends up set.
- R6: A read of any offset other than the six listed returns 0. Offsets are compared on all 8 bits, so an unaligned offset such as 0x11 counts as unmapped.
- R7: A write to an unmapped offset changes no register.
- R8: A write to one mapped register leaves every other register unchanged.
- R9: `rd_valid` is 1 exactly in the cycle after `rd_en`, with registered `rd_data`. A read that shares a cycle with a write returns the value held before that write. `rd_data` is 0 when `rd_valid` is 0.
- R10: With `TRACE_EN=1`, every access is reported one cycle after it is accepted. A read raises `trace_rd` and a write raises `trace_wr`. The report carries the offset in `trace_off` and the write data in `trace_wdata` (0 for a read-only access). `trace_hit` is 1 only for a mapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| reg_off | input | 8 | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| set_flags | input | 16 | Sets pending status flags |
| trace_rd | output | 1 | Trace: a read was accepted last cycle |
| trace_wr | output | 1 | Trace: a write was accepted last cycle |
| trace_hit | output | 1 | Trace: the traced offset was mapped |
| trace_off | output | 8 | Trace: offset of the traced access |
| trace_wdata | output | 32 | Trace: write data of the traced access |

## Verification
The bench builds the block with its defaults: a 32-bit data width, which gives a 16-bit flag half, and `TRACE_EN=1`. With tracing on, the report of each access, the hit flag for unmapped and unaligned offsets, and the one-cycle report latency can all be checked at the ports. The 16/16 split lets the bench check flags and mask separately with patterns that differ between the halves. It also drives one cycle where a set collides with a clear of the same bit.

// File: rtl/dgr_pkg.sv
package dgr_pkg;

  localparam int OFF_W = 8;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_PRIO  = 3'd1,
    SEL_SKIP  = 3'd2,
    SEL_RSIZE = 3'd3,
    SEL_ROFS  = 3'd4,
    SEL_STAT  = 3'd5,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  localparam int NUM_PLAIN = 5;

  // Full 8-bit compare: unaligned offsets fall through to SEL_NONE.
  function automatic reg_sel_e off_to_sel(input logic [OFF_W-1:0] off);
    reg_sel_e s;
    case (off)
      8'h00:   s = SEL_CTRL;
      8'h10:   s = SEL_STAT;
      8'h20:   s = SEL_PRIO;
      8'h30:   s = SEL_SKIP;
      8'h40:   s = SEL_RSIZE;
      8'h50:   s = SEL_ROFS;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dgr_decode.sv
module dgr_decode
  import dgr_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  output reg_sel_e         sel,
  output logic             hit
);
  always_comb begin
    sel = off_to_sel(off);
    hit = (sel != SEL_NONE);
  end
endmodule

// File: rtl/dgr_plain_bank.sv
module dgr_plain_bank #(
  parameter int NUM    = 5,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM-1:0]             wr_sel,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM-1:0][DATA_W-1:0] q
);
  for (genvar i = 0; i < NUM; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[i] <= '0;
      else if (wr_sel[i]) q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/dgr_status.sv
module dgr_status #(
  parameter int DATA_W = 32,
  localparam int FLAG_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] set_flags,
  output logic [DATA_W-1:0] q
);
  logic [FLAG_W-1:0] flags_q, mask_q, clr;

  assign clr = wr ? wr_data[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      // Set input dominates a same-cycle clear.
      flags_q <= (flags_q & ~clr) | set_flags;
      if (wr) mask_q <= wr_data[DATA_W-1:FLAG_W];
    end
  end

  assign q = {mask_q, flags_q};
endmodule

// File: rtl/dgr_trace.sv
module dgr_trace
  import dgr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit TRACE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              hit,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wr_data,
  output logic              t_rd,
  output logic              t_wr,
  output logic              t_hit,
  output logic [OFF_W-1:0]  t_off,
  output logic [DATA_W-1:0] t_wdata
);
  if (TRACE_EN) begin : g_on
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_rd    <= 1'b0;
        t_wr    <= 1'b0;
        t_hit   <= 1'b0;
        t_off   <= '0;
        t_wdata <= '0;
      end else begin
        t_rd    <= rd_en;
        t_wr    <= wr_en;
        t_hit   <= (rd_en | wr_en) & hit;
        t_off   <= (rd_en | wr_en) ? off : '0;
        t_wdata <= wr_en ? wr_data : '0;
      end
    end
  end else begin : g_off
    assign t_rd    = 1'b0;
    assign t_wr    = 1'b0;
    assign t_hit   = 1'b0;
    assign t_off   = '0;
    assign t_wdata = '0;
  end
endmodule

// File: rtl/dma_glob_regs.sv
module dma_glob_regs
  import dgr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit TRACE_EN = 1'b1,
  localparam int FLAG_W  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [FLAG_W-1:0] set_flags,
  output logic              trace_rd,
  output logic              trace_wr,
  output logic              trace_hit,
  output logic [OFF_W-1:0]  trace_off,
  output logic [DATA_W-1:0] trace_wdata
);
  reg_sel_e                          sel;
  logic                              hit;
  logic [NUM_PLAIN-1:0]              plain_wr;
  logic [NUM_PLAIN-1:0][DATA_W-1:0]  plain_q;
  logic [DATA_W-1:0]                 stat_word;
  logic [DATA_W-1:0]                 rd_mux;

  dgr_decode dec_i (.off(reg_off), .sel(sel), .hit(hit));

  for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_wsel
    assign plain_wr[i] = wr_en && (sel == reg_sel_e'(3'(i)));
  end

  dgr_plain_bank #(.NUM(NUM_PLAIN), .DATA_W(DATA_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_sel(plain_wr), .wr_data(wr_data), .q(plain_q)
  );

  dgr_status #(.DATA_W(DATA_W)) stat_i (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && (sel == SEL_STAT)),
    .wr_data(wr_data), .set_flags(set_flags), .q(stat_word)
  );

  always_comb begin
    rd_mux = '0;
    if (sel == SEL_STAT) rd_mux = stat_word;
    for (int i = 0; i < NUM_PLAIN; i++) begin
      if (sel == reg_sel_e'(3'(i))) rd_mux = plain_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_mux : '0;
    end
  end

  dgr_trace #(.DATA_W(DATA_W), .TRACE_EN(TRACE_EN)) trc_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .hit(hit),
    .off(reg_off), .wr_data(wr_data),
    .t_rd(trace_rd), .t_wr(trace_wr), .t_hit(trace_hit),
    .t_off(trace_off), .t_wdata(trace_wdata)
  );
endmodule

// File: rtl/dgr_checker.sv
module dgr_checker #(
  parameter int DATA_W   = 32,
  parameter bit TRACE_EN = 1'b1,
  localparam int FLAG_W  = DATA_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        reg_off,
  input logic [DATA_W-1:0] wr_data,
  input logic [FLAG_W-1:0] set_flags,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              trace_wr,
  input logic              trace_rd,
  input logic [DATA_W-1:0] stat_word
);
  logic mapped;
  assign mapped = (reg_off == 8'h00) || (reg_off == 8'h10) || (reg_off == 8'h20) ||
                  (reg_off == 8'h30) || (reg_off == 8'h40) || (reg_off == 8'h50);

  // R9
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && rd_data == '0));
  // R6
  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rd_data == '0));
  // R3
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_off == 8'h10) |=>
      ((stat_word[FLAG_W-1:0] & $past(wr_data[FLAG_W-1:0]) & ~$past(set_flags)) == '0));
  // R4
  a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_off == 8'h10) |=> (stat_word[DATA_W-1:FLAG_W] == $past(wr_data[DATA_W-1:FLAG_W])));
  // R5
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags != '0) |=> ((stat_word[FLAG_W-1:0] & $past(set_flags)) == $past(set_flags)));
  // R7
  a_r7_unmapped_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped && set_flags == '0) |=> $stable(stat_word));

  if (TRACE_EN) begin : g_trc
    // R10
    a_r10_trace_wr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> trace_wr);
    a_r10_trace_rd: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> trace_rd);
  end
endmodule

bind dma_glob_regs dgr_checker #(.DATA_W(DATA_W), .TRACE_EN(TRACE_EN)) chk_i (.*);

// File: tb/dma_glob_regs_tb_top.sv
module dma_glob_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  reg_off = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [15:0] set_flags = '0;
  logic        trace_rd, trace_wr, trace_hit;
  logic [7:0]  trace_off;
  logic [31:0] trace_wdata;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dma_glob_regs #(.DATA_W(32), .TRACE_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_off(reg_off), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .set_flags(set_flags),
    .trace_rd(trace_rd), .trace_wr(trace_wr), .trace_hit(trace_hit),
    .trace_off(trace_off), .trace_wdata(trace_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs change at negedge; results are sampled at the following negedge.
  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_off = off; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] d, input string req);
    @(negedge clk);
    rd_en = 1'b1; reg_off = off;
    @(negedge clk);
    rd_en = 1'b0;
    chk({req, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic rd_chk(input logic [7:0] off, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(off, d, req);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
    chk("R1 trace", {29'b0, trace_rd, trace_wr, trace_hit}, 32'd0);
    rd_chk(8'h00, 32'h0, "R1 ctrl");
    rd_chk(8'h10, 32'h0, "R1 stat");
    rd_chk(8'h20, 32'h0, "R1 prio");
    rd_chk(8'h30, 32'h0, "R1 skip");
    rd_chk(8'h40, 32'h0, "R1 rsize");
    rd_chk(8'h50, 32'h0, "R1 rofs");
  endtask

  task automatic t_plain();
    wr(8'h00, 32'h1111_0001);
    wr(8'h20, 32'h2222_0002);
    wr(8'h30, 32'h3333_0003);
    wr(8'h40, 32'h4444_0004);
    wr(8'h50, 32'h5555_0005);
    rd_chk(8'h00, 32'h1111_0001, "R2 ctrl");
    rd_chk(8'h20, 32'h2222_0002, "R2 prio");
    rd_chk(8'h30, 32'h3333_0003, "R2 skip");
    rd_chk(8'h40, 32'h4444_0004, "R2 rsize");
    rd_chk(8'h50, 32'h5555_0005, "R2 rofs");
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'h1111_0001, "R8 ctrl after prio write");
    rd_chk(8'h30, 32'h3333_0003, "R8 skip after prio write");
    rd_chk(8'h10, 32'h0, "R8 stat after prio write");
    wr(8'h10, 32'hABCD_0000);
    rd_chk(8'h50, 32'h5555_0005, "R8 rofs after stat write");
    rd_chk(8'h20, 32'hFFFF_FFFF, "R8 prio after stat write");
  endtask

  task automatic t_status();
    @(negedge clk); set_flags = 16'hA5F0;
    @(negedge clk); set_flags = '0;
    rd_chk(8'h10, 32'hABCD_A5F0, "R5 set flags");
    wr(8'h10, 32'h1234_00F0);
    rd_chk(8'h10, 32'h1234_A500, "R3 W1C partial / R4 mask");
    wr(8'h10, 32'h0000_0000);
    rd_chk(8'h10, 32'h0000_A500, "R4 mask zeroed, R3 zeros keep flags");
    wr(8'h10, 32'hFFFF_0000);
    rd_chk(8'h10, 32'hFFFF_A500, "R4 mask all ones");
    // same-cycle set and clear of bit 10
    @(negedge clk);
    wr_en = 1'b1; reg_off = 8'h10; wr_data = 32'h0000_0500; set_flags = 16'h0400;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; set_flags = '0;
    rd_chk(8'h10, 32'h0000_A400, "R5 set wins over clear");
    wr(8'h10, 32'h0000_FFFF);
    rd_chk(8'h10, 32'h0, "R3 clear all");
  endtask

  task automatic t_unknown();
    wr(8'h04, 32'hDEAD_BEEF);
    wr(8'h11, 32'hDEAD_BEEF);
    wr(8'h60, 32'hDEAD_BEEF);
    wr(8'hFF, 32'hDEAD_BEEF);
    rd_chk(8'h00, 32'h1111_0001, "R7 ctrl intact");
    rd_chk(8'h10, 32'h0, "R7 stat intact");
    rd_chk(8'h20, 32'hFFFF_FFFF, "R7 prio intact");
    rd_chk(8'h30, 32'h3333_0003, "R7 skip intact");
    rd_chk(8'h40, 32'h4444_0004, "R7 rsize intact");
    rd_chk(8'h50, 32'h5555_0005, "R7 rofs intact");
    rd_chk(8'h04, 32'h0, "R6 unaligned 0x04");
    rd_chk(8'h11, 32'h0, "R6 unaligned 0x11");
    rd_chk(8'h60, 32'h0, "R6 unmapped 0x60");
    rd_chk(8'hF0, 32'h0, "R6 unmapped 0xF0");
  endtask

  task automatic t_timing();
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; reg_off = 8'h00; wr_data = 32'hCAFE_0000;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    chk("R9 read with write valid", {31'b0, rd_valid}, 32'd1);
    chk("R9 read with write old value", rd_data, 32'h1111_0001);
    @(negedge clk);
    chk("R9 valid one cycle only", {31'b0, rd_valid}, 32'd0);
    chk("R9 data zero when idle", rd_data, 32'd0);
    rd_chk(8'h00, 32'hCAFE_0000, "R9 new value after write");
  endtask

  task automatic t_trace();
    @(negedge clk);
    wr_en = 1'b1; reg_off = 8'h40; wr_data = 32'h0BAD_F00D;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk("R10 wr flags", {29'b0, trace_rd, trace_wr, trace_hit}, 32'b011);
    chk("R10 wr off", {24'b0, trace_off}, 32'h40);
    chk("R10 wr data", trace_wdata, 32'h0BAD_F00D);
    @(negedge clk);
    wr_en = 1'b1; reg_off = 8'h60; wr_data = 32'h1234_5678;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk("R10 unmapped wr flags", {29'b0, trace_rd, trace_wr, trace_hit}, 32'b010);
    chk("R10 unmapped wr off", {24'b0, trace_off}, 32'h60);
    @(negedge clk);
    rd_en = 1'b1; reg_off = 8'h10;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 rd flags", {29'b0, trace_rd, trace_wr, trace_hit}, 32'b101);
    chk("R10 rd wdata zero", trace_wdata, 32'h0);
    @(negedge clk);
    chk("R10 idle", {29'b0, trace_rd, trace_wr, trace_hit}, 32'b000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_status();
        t_unknown();
        t_timing();
        t_trace();
      end
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule